// File: doc/BRIEF.md
# Serial Port Transfer Clock Generator

This block makes the bit clock for a byte-wide synchronous serial port. It runs entirely in the system clock domain. Two on-chip sources arrive as tick strobes: a low-speed clock and a faster oscillator clock. Each tick marks one edge of that source, so a tick input carries twice the source frequency. A 3-bit select picks one of these sources at a fixed ratio, or the external clock pin. Picking an internal source makes the port the master, and it drives the clock pin. Picking the pin makes the port a slave, which follows an external clock that is synchronized into the system domain.

A transfer begins on the rising edge of the transfer-active input. The clock settings are sampled at that moment and held for the whole byte. The clock then runs exactly eight periods and returns to its idle level, and a one-cycle done pulse marks the end. A shift strobe marks each leading edge of the port clock and a sample strobe marks each trailing edge; an attached shift register acts on these strobes. Two control bits set the idle level of the clock and an overall logic inversion. One select code is reserved and yields a stopped clock.

Top module: `tclk_gen`

## Requirements
- R1: After reset the block is in master mode (select code 000), sck_oe_o is 1, sck_o is high, and shift_o, sample_o and done_o are 0.
- R2: Select codes 000 and 001 use ls_tick_i and give a half-period of 1 and 2 ticks. Strobes are registered and so appear one cycle after the tick that completes a half-period. The strobe spacing therefore follows the tick spacing and not the system clock.
- R3: Select codes 010, 011, 100 and 101 use osc_tick_i and give half-periods of 4, 8, 16 and 32 ticks.
- R4: Select code 110 is slave mode. master_o and sck_oe_o are 0 and sck_o stays at its idle level. Each change of sck_i, seen after a 2-stage synchronizer, counts as one port clock edge.
- R5: Select code 111 is reserved. master_o stays 1 and sck_o stays at its idle level. A transfer that is held active produces no strobes and no done pulse.
- R6: The idle level of sck_o is (not idle_low_i) xor invert_i, so (0,0) gives 1, (1,0) gives 0, (0,1) gives 0 and (1,1) gives 1. While the clock is active, sck_o is the complement of that level.
- R7: Every transfer produces exactly 8 shift strobes and 8 sample strobes, strictly alternating and starting with a shift. done_o pulses once, in the same cycle as the 8th sample strobe, and sck_o is back at its idle level in that cycle.
- R8: In master mode, shift_o is high in the cycle in which sck_o leaves its idle level, and sample_o is high in the cycle in which sck_o returns to it. shift_o and sample_o are never high together.
- R9: The select, idle-level and inversion settings are sampled at transfer start. Changes made to them during the transfer do not alter the strobe spacing or the levels of that transfer.
- R10: A transfer starts only on a rising edge of xfer_i. Keeping xfer_i high after done does not start another transfer. Lowering xfer_i mid-transfer aborts it: sck_o goes back to idle and no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ls_tick_i | input | 1 | One pulse per edge of the low-speed source clock |
| osc_tick_i | input | 1 | One pulse per edge of the oscillator source clock |
| clk_sel_i | input | 3 | Transfer clock select code |
| idle_low_i | input | 1 | 0: clock idles high, 1: clock idles low |
| invert_i | input | 1 | 1: negative logic on the clock |
| xfer_i | input | 1 | Transfer active; rising edge starts a byte |
| sck_i | input | 1 | External clock pin input (slave) |
| sck_o | output | 1 | Port clock output level |
| sck_oe_o | output | 1 | Clock pin output enable (master) |
| master_o | output | 1 | 1 = master, 0 = slave |
| shift_o | output | 1 | Leading-edge strobe |
| sample_o | output | 1 | Trailing-edge strobe |
| done_o | output | 1 | One-cycle end-of-byte pulse |

## Verification
Every select ratio is timed from the spacing of its strobes. A divider that decoded the wrong counter bits, or that counted system cycles instead of ticks, would produce a wrong interval; a slowed tick pattern catches the second case. The four combinations of idle level and inversion are each checked, both at idle and during the active phase, to expose a swapped or missing xor. A mid-transfer select change catches a block that fails to hold its settings for the byte. The reserved code, a held transfer input after done, and an abort catch a clock that runs away, a transfer that restarts by itself, and a done pulse raised without eight full periods.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

  typedef enum logic [2:0] {
    SEL_LS1   = 3'd0,
    SEL_LS2   = 3'd1,
    SEL_OSC4  = 3'd2,
    SEL_OSC8  = 3'd3,
    SEL_OSC16 = 3'd4,
    SEL_OSC32 = 3'd5,
    SEL_EXT   = 3'd6,
    SEL_RSVD  = 3'd7
  } clk_sel_e;

  typedef struct packed {
    clk_sel_e sel;
    logic     idle_low;
    logic     invert;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{sel: SEL_LS1, idle_low: 1'b0, invert: 1'b0};

endpackage

// File: rtl/tclk_ctr.sv
module tclk_ctr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/tclk_div.sv
module tclk_div
  import tclk_pkg::*;
#(
  parameter int LS_W  = 1,
  parameter int OSC_W = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ls_tick_i,
  input  logic     osc_tick_i,
  input  clk_sel_e sel_i,
  output logic     ev_o
);

  localparam int NSRC = 2;
  localparam int MAXW = (LS_W > OSC_W) ? LS_W : OSC_W;

  logic [NSRC-1:0]           tick;
  logic [NSRC-1:0][MAXW-1:0] cnt;
  logic [NSRC-1:0]           hit;

  assign tick = {osc_tick_i, ls_tick_i};

  // Each source gets its own free-running counter. Half-period = 2^mask bits,
  // and the number of mask bits equals the select code.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int SW = (s == 0) ? LS_W : OSC_W;
    logic [SW-1:0] c;
    logic [SW-1:0] mask;

    tclk_ctr #(.W(SW)) i_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick[s]),
      .cnt_o  (c)
    );

    always_comb begin
      for (int i = 0; i < SW; i++) mask[i] = (i < int'(sel_i));
    end

    assign cnt[s] = MAXW'(c);
    assign hit[s] = tick[s] && (&(c | ~mask));
  end

  always_comb begin
    unique case (sel_i)
      SEL_LS1, SEL_LS2:                          ev_o = hit[0];
      SEL_OSC4, SEL_OSC8, SEL_OSC16, SEL_OSC32:  ev_o = hit[1];
      default:                                   ev_o = 1'b0;
    endcase
  end

  logic unused_cnt;
  assign unused_cnt = ^cnt;

endmodule

// File: rtl/tclk_sync.sv
module tclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic chg_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];
  assign chg_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/tclk_seq.sv
module tclk_seq #(
  parameter int EDGES = 16,
  localparam int CW   = $clog2(EDGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_i,
  input  logic          ev_i,
  output logic          run_o,
  output logic          phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          shift_o,
  output logic          sample_o,
  output logic          done_o
);

  logic xfer_q;
  logic start;
  logic step;
  logic last;

  assign start = xfer_i && !xfer_q && !run_o;
  assign step  = run_o && xfer_i && ev_i;
  assign last  = (cnt_o == CW'(EDGES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q   <= 1'b0;
      run_o    <= 1'b0;
      phase_o  <= 1'b0;
      cnt_o    <= '0;
      shift_o  <= 1'b0;
      sample_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      xfer_q   <= xfer_i;
      shift_o  <= step && !phase_o;
      sample_o <= step && phase_o;
      done_o   <= step && last;
      if (!xfer_i) begin
        run_o   <= 1'b0;
        phase_o <= 1'b0;
        cnt_o   <= '0;
      end else if (start) begin
        run_o   <= 1'b1;
        phase_o <= 1'b0;
        cnt_o   <= '0;
      end else if (step) begin
        phase_o <= !phase_o;
        cnt_o   <= cnt_o + 1'b1;
        if (last) run_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tclk_gen.sv
module tclk_gen
  import tclk_pkg::*;
#(
  parameter int BITS_PER_XFER = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int LS_DIV_W      = 1,
  parameter int OSC_DIV_W     = 5,
  localparam int EDGES        = 2 * BITS_PER_XFER,
  localparam int CW           = $clog2(EDGES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ls_tick_i,
  input  logic       osc_tick_i,
  input  logic [2:0] clk_sel_i,
  input  logic       idle_low_i,
  input  logic       invert_i,
  input  logic       xfer_i,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  output logic       master_o,
  output logic       shift_o,
  output logic       sample_o,
  output logic       done_o
);

  clk_cfg_t cfg_q;
  clk_cfg_t cfg_d;
  logic     run;
  logic     phase;
  logic [CW-1:0] edge_cnt;
  logic     div_ev;
  logic     ext_lvl;
  logic     ext_chg;
  logic     ev;
  logic     idle_lvl;

  assign cfg_d = '{sel: clk_sel_e'(clk_sel_i), idle_low: idle_low_i, invert: invert_i};

  // Settings track the inputs while idle and freeze for the byte.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (!run) cfg_q <= cfg_d;
  end

  tclk_div #(.LS_W(LS_DIV_W), .OSC_W(OSC_DIV_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ls_tick_i  (ls_tick_i),
    .osc_tick_i (osc_tick_i),
    .sel_i      (cfg_q.sel),
    .ev_o       (div_ev)
  );

  tclk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sck_i),
    .lvl_o  (ext_lvl),
    .chg_o  (ext_chg)
  );

  assign master_o = (cfg_q.sel != SEL_EXT);
  assign ev       = master_o ? div_ev : ext_chg;

  tclk_seq #(.EDGES(EDGES)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (xfer_i),
    .ev_i     (ev),
    .run_o    (run),
    .phase_o  (phase),
    .cnt_o    (edge_cnt),
    .shift_o  (shift_o),
    .sample_o (sample_o),
    .done_o   (done_o)
  );

  assign idle_lvl = !cfg_q.idle_low ^ cfg_q.invert;
  assign sck_o    = master_o ? (idle_lvl ^ phase) : idle_lvl;
  assign sck_oe_o = master_o;

  logic unused_lvl;
  assign unused_lvl = ext_lvl;

endmodule

// File: rtl/tclk_gen_chk.sv
module tclk_gen_chk #(
  parameter int EDGES = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run,
  input logic [2:0]    cfg_sel,
  input logic [CW-1:0] edge_cnt,
  input logic          sck_o,
  input logic          sck_oe_o,
  input logic          shift_o,
  input logic          sample_o,
  input logic          done_o
);

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_o && sample_o));

  assert_done_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sample_o);

  assert_cnt_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(edge_cnt) <= EDGES);

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> $stable(cfg_sel));

  assert_rsvd_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel == 3'b111) |-> (!shift_o && !sample_o && !done_o));

  assert_edge_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && sck_oe_o && (sck_o != $past(sck_o))) |-> (shift_o || sample_o));

  assert_slave_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_oe_o && run && $past(run)) |-> $stable(sck_o));

endmodule

bind tclk_gen tclk_gen_chk #(.EDGES(EDGES), .CW(CW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run      (run),
  .cfg_sel  (cfg_q.sel),
  .edge_cnt (edge_cnt),
  .sck_o    (sck_o),
  .sck_oe_o (sck_oe_o),
  .shift_o  (shift_o),
  .sample_o (sample_o),
  .done_o   (done_o)
);

// File: tb/test_tclk_gen.sv
module test_tclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ls_tick = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       idle_low = 1'b0;
  logic       invert = 1'b0;
  logic       xfer = 1'b0;
  logic       sck_in = 1'b0;
  logic       sck_out, sck_oe, master, shift, sample, done;

  int total = 0;
  int bad = 0;
  int ls_per = 1;
  int osc_per = 1;
  int cyc = 0;

  tclk_gen i_tclk_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ls_tick_i  (ls_tick),
    .osc_tick_i (osc_tick),
    .clk_sel_i  (sel),
    .idle_low_i (idle_low),
    .invert_i   (invert),
    .xfer_i     (xfer),
    .sck_i      (sck_in),
    .sck_o      (sck_out),
    .sck_oe_o   (sck_oe),
    .master_o   (master),
    .shift_o    (shift),
    .sample_o   (sample),
    .done_o     (done)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ls_tick  = (cyc % ls_per) == 0;
      osc_tick = (cyc % osc_per) == 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Watches strobes at falling edges until done or timeout.
  task automatic capture(input int max_cyc, input int exp_iv, input bit chk_lvl, input bit exp_idle,
                         output int ns, output int nsm, output int nd,
                         output int iv_bad, output int ord_bad, output int lvl_bad);
    int last = -1;
    bit want_shift = 1'b1;
    ns = 0; nsm = 0; nd = 0; iv_bad = 0; ord_bad = 0; lvl_bad = 0;
    for (int c = 0; c < max_cyc; c++) begin
      @(negedge clk);
      if (shift || sample) begin
        if (last >= 0 && (c - last) != exp_iv) iv_bad++;
        last = c;
        if ((shift && !want_shift) || (sample && want_shift) || (shift && sample)) ord_bad++;
        want_shift = sample;
        if (shift) ns++;
        if (sample) nsm++;
        if (chk_lvl && (sck_out != (shift ? !exp_idle : exp_idle))) lvl_bad++;
      end
      if (done) begin
        nd++;
        if (!sample || nsm != 8) ord_bad++;
        break;
      end
    end
  endtask

  task automatic start_xfer();
    @(negedge clk);
    xfer = 1'b1;
  endtask

  task automatic stop_xfer();
    @(negedge clk);
    xfer = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "sck_o", sck_out, 1);
    chk("R1", "sck_oe_o", sck_oe, 1);
    chk("R1", "master_o", master, 1);
    chk("R1", "strobes", int'(shift) + int'(sample) + int'(done), 0);
  endtask

  task automatic t_rates();
    int ns, nsm, nd, ivb, ob, lb;
    for (int code = 0; code < 6; code++) begin
      int n = (code == 0) ? 1 : (code == 1) ? 2 : (4 << (code - 2));
      string r = (code < 2) ? "R2" : "R3";
      sel = 3'(code); idle_low = 1'b0; invert = 1'b0;
      repeat (3) @(negedge clk);
      start_xfer();
      capture(40 * n + 50, n, 1'b1, 1'b1, ns, nsm, nd, ivb, ob, lb);
      chk(r, $sformatf("code %0d interval errors", code), ivb, 0);
      chk("R7", $sformatf("code %0d shifts", code), ns, 8);
      chk("R7", $sformatf("code %0d samples", code), nsm, 8);
      chk("R7", $sformatf("code %0d done", code), nd, 1);
      chk("R7", $sformatf("code %0d order", code), ob, 0);
      chk("R8", $sformatf("code %0d edge levels", code), lb, 0);
      @(negedge clk);
      chk("R7", "idle after done", sck_out, 1);
      stop_xfer();
    end
  endtask

  task automatic t_slow_ticks();
    int ns, nsm, nd, ivb, ob, lb;
    ls_per = 3; sel = 3'd1;
    repeat (4) @(negedge clk);
    start_xfer();
    capture(300, 6, 1'b1, 1'b1, ns, nsm, nd, ivb, ob, lb);
    chk("R2", "tick-paced interval errors", ivb, 0);
    chk("R2", "tick-paced done", nd, 1);
    stop_xfer();
    ls_per = 1;
  endtask

  task automatic t_levels();
    int ns, nsm, nd, ivb, ob, lb;
    for (int k = 0; k < 4; k++) begin
      bit il = k[0];
      bit inv = k[1];
      bit exp_idle = !il ^ inv;
      sel = 3'd1; idle_low = il; invert = inv;
      repeat (3) @(negedge clk);
      chk("R6", $sformatf("idle level il=%0d inv=%0d", il, inv), sck_out, int'(exp_idle));
      start_xfer();
      capture(200, 2, 1'b1, exp_idle, ns, nsm, nd, ivb, ob, lb);
      chk("R6", $sformatf("active levels il=%0d inv=%0d", il, inv), lb, 0);
      chk("R6", $sformatf("done il=%0d inv=%0d", il, inv), nd, 1);
      stop_xfer();
    end
    idle_low = 1'b0; invert = 1'b0;
  endtask

  task automatic t_slave();
    int ns, nsm, nd, ivb, ob, lb;
    sel = 3'd6; sck_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "master_o in slave", master, 0);
    chk("R4", "sck_oe_o in slave", sck_oe, 0);
    start_xfer();
    fork
      begin
        repeat (16) begin
          repeat (4) @(negedge clk);
          sck_in = ~sck_in;
        end
      end
      capture(200, 4, 1'b0, 1'b1, ns, nsm, nd, ivb, ob, lb);
    join
    chk("R4", "slave shifts", ns, 8);
    chk("R4", "slave samples", nsm, 8);
    chk("R4", "slave done", nd, 1);
    chk("R4", "slave interval errors", ivb, 0);
    chk("R4", "slave sck_o idle", sck_out, 1);
    stop_xfer();
  endtask

  task automatic t_reserved();
    int ns, nsm, nd, ivb, ob, lb;
    sel = 3'd7;
    repeat (3) @(negedge clk);
    start_xfer();
    capture(300, 1, 1'b0, 1'b1, ns, nsm, nd, ivb, ob, lb);
    chk("R5", "reserved strobes", ns + nsm, 0);
    chk("R5", "reserved done", nd, 0);
    chk("R5", "reserved master_o", master, 1);
    chk("R5", "reserved sck_o idle", sck_out, 1);
    stop_xfer();
  endtask

  task automatic t_freeze();
    int ns, nsm, nd, ivb, ob, lb;
    sel = 3'd2;
    repeat (3) @(negedge clk);
    start_xfer();
    fork
      begin
        repeat (10) @(negedge clk);
        sel = 3'd5; invert = 1'b1;
      end
      capture(300, 4, 1'b1, 1'b1, ns, nsm, nd, ivb, ob, lb);
    join
    chk("R9", "frozen interval errors", ivb, 0);
    chk("R9", "frozen levels", lb, 0);
    chk("R9", "frozen done", nd, 1);
    stop_xfer();
    invert = 1'b0;
  endtask

  task automatic t_abort();
    int ns, nsm, nd, ivb, ob, lb;
    sel = 3'd3;
    repeat (3) @(negedge clk);
    start_xfer();
    capture(50, 8, 1'b1, 1'b1, ns, nsm, nd, ivb, ob, lb);
    chk("R10", "no done before abort", nd, 0);
    stop_xfer();
    chk("R10", "idle after abort", sck_out, 1);
    chk("R10", "no done after abort", int'(done), 0);
    start_xfer();
    capture(400, 8, 1'b1, 1'b1, ns, nsm, nd, ivb, ob, lb);
    chk("R10", "full byte after abort", ns + nsm, 16);
    chk("R10", "done after abort", nd, 1);
    capture(200, 8, 1'b0, 1'b1, ns, nsm, nd, ivb, ob, lb);
    chk("R10", "no restart while held", ns + nsm + nd, 0);
    stop_xfer();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rates();
    t_slow_ticks();
    t_levels();
    t_slave();
    t_reserved();
    t_freeze();
    t_abort();
    summary();
    $finish;
  end

endmodule